// File: doc/BRIEF.md
# Modem-line automatic flow controller

This block runs the hardware handshake lines of a serial port without software. On the receive side it compares the receive FIFO fill level with two thresholds, an upper one and a lower one. It drops the request-to-send output, or the data-terminal-ready output, when the FIFO is nearly full. It raises that output again only after the FIFO has drained to the lower threshold, so the gap between the two thresholds gives hysteresis. On the transmit side it watches the clear-to-send and data-set-ready inputs, which may change at any time. It passes them through a two-stage synchroniser and blocks the start of further data characters while an enabled input is inactive.

The transmit gate changes state only between characters, so a character that is already on the line always finishes. A request to send a flow-control character overrides the gate. For RS-485 half-duplex use, the data-terminal-ready pin can instead show whether the transmitter is empty, with either polarity, so it can steer a line driver. Status outputs show whether each receive-side line is in its stopped state and whether the transmitter is held off. The block carries no data stream; all its pins are level-type control and status signals, so it needs no back-pressure rules.

Top module: `modem_flow_ctrl`

## Requirements
- R1: After reset, with both software bits at 0 and all automatic modes off, `rts_n` = 1, `dtr_n` = 1, `stat_rx_stop` = 2'b00, `stat_tx_halt` = 0 and `tx_allow` = 1.
- R2: While automatic control of a line is off, its active-low pin is the complement of its software bit (`rts_n` = ~`sw_rts`, `dtr_n` = ~`sw_dtr`), and the FIFO level has no effect on it.
- R3: With `auto_rts_en` set, the edge after `rx_level` >= `thr_hi` drives `rts_n` to 1. It stays 1 while the level is above `thr_lo`, and the edge after `rx_level` <= `thr_lo` drives it back to 0.
- R4: With `auto_dtr_en` set and `de_mode` = 2'b00, `dtr_n` follows the same two-threshold behaviour, independently of the RTS channel.
- R5: With `auto_cts_en` set and the transmitter idle, `cts_n` = 1 clears `tx_allow` three clock edges after it is applied. Two edges go to synchronisation and one to the gate register. `cts_n` = 0 restores `tx_allow` with the same latency.
- R6: While `tx_busy` is 1 the gate state (`stat_tx_halt`) does not change. A modem input change during a character takes effect on the first edge with `tx_busy` = 0.
- R7: With `auto_dsr_en` set, `dsr_n` gates the transmitter as in R5. A modem input whose automatic mode is off has no effect on the gate.
- R8: `tx_flow_go` = `flow_req` & ~`tx_busy` regardless of the modem inputs, and `tx_allow` is 0 while `flow_req` is 1.
- R9: `de_mode` = 2'b01 sets `dtr_n` = ~`tx_empty`; `de_mode` = 2'b11 sets `dtr_n` = `tx_empty`; 2'b00 and 2'b10 give the normal DTR behaviour.
- R10: `stat_rx_stop[0]` (RTS) and `stat_rx_stop[1]` (DTR) are 1 exactly while that channel is in its stopped state. `stat_tx_halt` is 1 while the gate holds off data characters, and then `tx_allow` is 0.
- R11: The thresholds compare inclusively. A level equal to `thr_hi` stops the channel, a level equal to `thr_lo` releases it, and a level strictly between them keeps the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | 8 | Receive FIFO fill level |
| thr_hi | input | 8 | Upper (stop) threshold |
| thr_lo | input | 8 | Lower (resume) threshold |
| auto_rts_en | input | 1 | Automatic RTS control enable |
| auto_dtr_en | input | 1 | Automatic DTR control enable |
| auto_cts_en | input | 1 | Clear-to-send transmit gating enable |
| auto_dsr_en | input | 1 | Data-set-ready transmit gating enable |
| sw_rts | input | 1 | Software RTS bit, 1 = asserted |
| sw_dtr | input | 1 | Software DTR bit, 1 = asserted |
| de_mode | input | 2 | DTR pin function: 00/10 flow, 01 busy-high, 11 busy-low |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| tx_busy | input | 1 | A character is being shifted out |
| tx_empty | input | 1 | Transmit FIFO and shift register both empty |
| flow_req | input | 1 | Request to send a flow-control character |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| tx_allow | output | 1 | A data character may start |
| tx_flow_go | output | 1 | A flow-control character may start now |
| stat_rx_stop | output | 2 | Stopped state per receive line (bit0 RTS, bit1 DTR) |
| stat_tx_halt | output | 1 | Transmitter held off by modem inputs |

## Verification
The hardest situation to reach is a modem input that changes while a character is in flight, followed by the deferred update at the next character boundary. The stimulus holds `tx_busy` high, deasserts `cts_n`, and waits well beyond the three-edge synchroniser latency while checking that `tx_allow` has not moved. It then drops `tx_busy` and checks that the gate closes on exactly the next edge. The threshold channels are driven onto the levels equal to each threshold and onto levels just either side of them, to show that the hysteresis band keeps its state.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [1:0] {
    DE_FLOW    = 2'b00,
    DE_BUSY_HI = 2'b01,
    DE_FLOW_2  = 2'b10,
    DE_BUSY_LO = 2'b11
  } de_mode_e;

  localparam int CH_RTS = 0;
  localparam int CH_DTR = 1;
  localparam int N_CH   = 2;
endpackage

// File: rtl/mfc_sync.sv
module mfc_sync #(
  parameter int   W       = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mfc_hyst.sv
module mfc_hyst #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] hi,
  input  logic [LVL_W-1:0] lo,
  output logic             stop
);
  // Stopped state entered at or above hi, left at or below lo.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   stop <= 1'b0;
    else if (!en)                 stop <= 1'b0;
    else if (!stop && lvl >= hi)  stop <= 1'b1;
    else if (stop && lvl <= lo)   stop <= 1'b0;
  end
endmodule

// File: rtl/mfc_txgate.sv
module mfc_txgate (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic tx_busy,
  input  logic flow_req,
  output logic tx_allow,
  output logic flow_go,
  output logic halted
);
  // Gate only re-evaluated between characters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halted <= 1'b0;
    else if (!tx_busy) halted <= halt_req;
  end

  assign tx_allow = !halted && !flow_req;
  assign flow_go  = flow_req && !tx_busy;
endmodule

// File: rtl/modem_flow_ctrl.sv
module modem_flow_ctrl
  import mfc_pkg::*;
#(
  parameter int FIFO_DEPTH  = 128,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  input  logic             auto_rts_en,
  input  logic             auto_dtr_en,
  input  logic             auto_cts_en,
  input  logic             auto_dsr_en,
  input  logic             sw_rts,
  input  logic             sw_dtr,
  input  logic [1:0]       de_mode,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             tx_busy,
  input  logic             tx_empty,
  input  logic             flow_req,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             tx_allow,
  output logic             tx_flow_go,
  output logic [1:0]       stat_rx_stop,
  output logic             stat_tx_halt
);
  logic [N_CH-1:0] ch_en;
  logic [N_CH-1:0] ch_stop;
  logic [N_CH-1:0] sw_bit;
  logic [N_CH-1:0] ch_pin_n;
  logic [1:0]      mdm_s;
  logic            halt_req;

  assign ch_en[CH_RTS]  = auto_rts_en;
  assign ch_en[CH_DTR]  = auto_dtr_en;
  assign sw_bit[CH_RTS] = sw_rts;
  assign sw_bit[CH_DTR] = sw_dtr;

  genvar k;
  generate
    for (k = 0; k < N_CH; k++) begin : g_ch
      mfc_hyst #(.LVL_W(LVL_W)) u_hyst (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ch_en[k]),
        .lvl  (rx_level),
        .hi   (thr_hi),
        .lo   (thr_lo),
        .stop (ch_stop[k])
      );
      assign ch_pin_n[k] = ch_en[k] ? ch_stop[k] : !sw_bit[k];
    end
  endgenerate

  mfc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({dsr_n, cts_n}),
    .q    (mdm_s)
  );

  assign halt_req = (auto_cts_en && mdm_s[0]) || (auto_dsr_en && mdm_s[1]);

  mfc_txgate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt_req(halt_req),
    .tx_busy (tx_busy),
    .flow_req(flow_req),
    .tx_allow(tx_allow),
    .flow_go (tx_flow_go),
    .halted  (stat_tx_halt)
  );

  always_comb begin
    unique case (de_mode)
      DE_BUSY_HI: dtr_n = !tx_empty;
      DE_BUSY_LO: dtr_n = tx_empty;
      default:    dtr_n = ch_pin_n[CH_DTR];
    endcase
  end

  assign rts_n        = ch_pin_n[CH_RTS];
  assign stat_rx_stop = ch_stop;
endmodule

// File: rtl/mfc_chk.sv
module mfc_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] thr_hi,
  input logic             auto_rts_en,
  input logic             auto_dtr_en,
  input logic             sw_rts,
  input logic             rts_n,
  input logic             dtr_n,
  input logic [1:0]       de_mode,
  input logic             tx_empty,
  input logic             tx_busy,
  input logic             flow_req,
  input logic             tx_allow,
  input logic             tx_flow_go,
  input logic             stat_tx_halt,
  input logic [1:0]       stat_rx_stop
);
  a_r2_manual_rts: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |-> (rts_n == !sw_rts));

  a_r3_rts_stop_at_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level >= thr_hi) |=> (!auto_rts_en || (stat_rx_stop[0] && rts_n)));

  a_r4_dtr_stop_at_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_dtr_en && rx_level >= thr_hi) |=> (!auto_dtr_en || stat_rx_stop[1]));

  a_r6_hold_mid_char: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable(stat_tx_halt));

  a_r8_flow_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_req && !tx_busy) |-> (tx_flow_go && !tx_allow));

  a_r9_de_busy_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (de_mode == 2'b01) |-> (dtr_n == !tx_empty));

  a_r10_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stat_tx_halt |-> !tx_allow);
endmodule

bind modem_flow_ctrl mfc_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/modem_flow_ctrl_tb.sv
module modem_flow_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_level = '0, thr_hi = 8'd100, thr_lo = 8'd20;
  logic       auto_rts_en = 0, auto_dtr_en = 0, auto_cts_en = 0, auto_dsr_en = 0;
  logic       sw_rts = 0, sw_dtr = 0;
  logic [1:0] de_mode = 2'b00;
  logic       cts_n = 0, dsr_n = 0, tx_busy = 0, tx_empty = 1, flow_req = 0;
  logic       rts_n, dtr_n, tx_allow, tx_flow_go, stat_tx_halt;
  logic [1:0] stat_rx_stop;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  modem_flow_ctrl u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rts_n", rts_n, 1);
    chk("R1 dtr_n", dtr_n, 1);
    chk("R1 stat_rx_stop", stat_rx_stop, 0);
    chk("R1 stat_tx_halt", stat_tx_halt, 0);
    chk("R1 tx_allow", tx_allow, 1);
  endtask

  task automatic t_manual;
    rx_level = 8'd120;
    sw_rts = 1; sw_dtr = 0; step(2);
    chk("R2 rts_n sw=1 level ignored", rts_n, 0);
    chk("R2 dtr_n sw=0", dtr_n, 1);
    sw_rts = 0; sw_dtr = 1; step(1);
    chk("R2 rts_n sw=0", rts_n, 1);
    chk("R2 dtr_n sw=1", dtr_n, 0);
    sw_dtr = 0; rx_level = 0; step(1);
  endtask

  task automatic t_rts_hyst;
    thr_hi = 8'd100; thr_lo = 8'd20; auto_rts_en = 1;
    rx_level = 8'd99; step(1);
    chk("R3 below hi asserted", rts_n, 0);
    rx_level = 8'd100; step(1);
    chk("R11 equal hi stops", rts_n, 1);
    chk("R10 stat rts stop", stat_rx_stop[0], 1);
    rx_level = 8'd50; step(2);
    chk("R11 in band keeps stop", rts_n, 1);
    rx_level = 8'd21; step(1);
    chk("R3 just above lo", rts_n, 1);
    rx_level = 8'd20; step(1);
    chk("R11 equal lo releases", rts_n, 0);
    chk("R10 stat rts clear", stat_rx_stop[0], 0);
    rx_level = 8'd50; step(1);
    chk("R11 in band keeps run", rts_n, 0);
    auto_rts_en = 0; rx_level = 0; step(1);
  endtask

  task automatic t_dtr_hyst;
    thr_hi = 8'd10; thr_lo = 8'd5; auto_dtr_en = 1; sw_rts = 1;
    rx_level = 8'd10; step(1);
    chk("R4 dtr stops at hi", dtr_n, 1);
    chk("R4 rts channel independent", rts_n, 0);
    chk("R10 stat dtr stop", stat_rx_stop, 2'b10);
    rx_level = 8'd6; step(1);
    chk("R4 dtr holds above lo", dtr_n, 1);
    rx_level = 8'd5; step(1);
    chk("R4 dtr releases at lo", dtr_n, 0);
    sw_rts = 0; rx_level = 0; step(1);
  endtask

  task automatic t_rs485;
    de_mode = 2'b01; tx_empty = 0; step(1);
    chk("R9 mode01 busy", dtr_n, 1);
    tx_empty = 1; step(1);
    chk("R9 mode01 empty", dtr_n, 0);
    de_mode = 2'b11; step(1);
    chk("R9 mode11 empty", dtr_n, 1);
    tx_empty = 0; step(1);
    chk("R9 mode11 busy", dtr_n, 0);
    de_mode = 2'b10; tx_empty = 1; step(1);
    chk("R9 mode10 normal dtr", dtr_n, 0);
    auto_dtr_en = 0; de_mode = 2'b00; step(1);
  endtask

  task automatic t_cts;
    auto_cts_en = 1; cts_n = 1; step(2);
    chk("R5 not yet after 2 edges", tx_allow, 1);
    step(1);
    chk("R5 halted after 3 edges", tx_allow, 0);
    chk("R10 stat_tx_halt", stat_tx_halt, 1);
    cts_n = 0; step(3);
    chk("R5 resumed", tx_allow, 1);
    tx_busy = 1; step(1);
    cts_n = 1; step(8);
    chk("R6 no change mid char", tx_allow, 1);
    tx_busy = 0; step(1);
    chk("R6 change at boundary", tx_allow, 0);
    cts_n = 0; step(4);
    auto_cts_en = 0; step(1);
  endtask

  task automatic t_dsr;
    cts_n = 1; step(5);
    chk("R7 cts ignored when off", tx_allow, 1);
    auto_dsr_en = 1; dsr_n = 1; step(4);
    chk("R7 dsr halts", tx_allow, 0);
    dsr_n = 0; step(4);
    chk("R7 dsr resumes", tx_allow, 1);
    dsr_n = 1; step(4);
  endtask

  task automatic t_flow;
    chk("R8 precondition halted", stat_tx_halt, 1);
    flow_req = 1; step(1);
    chk("R8 flow go while halted", tx_flow_go, 1);
    chk("R8 data blocked", tx_allow, 0);
    tx_busy = 1; step(1);
    chk("R8 flow waits for boundary", tx_flow_go, 0);
    tx_busy = 0; flow_req = 0; dsr_n = 0; cts_n = 0; step(4);
    flow_req = 1; step(1);
    chk("R8 flow blocks data when running", tx_allow, 0);
    flow_req = 0; step(1);
    chk("R8 data back", tx_allow, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_manual();
    t_rts_hyst();
    t_dtr_hyst();
    t_rs485();
    t_cts();
    t_dsr();
    t_flow();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule